// File: doc/BRIEF.md
# DMA Request Descriptor Splitter

This block turns memory-copy requests into 128-bit descriptors and writes them into a circular descriptor ring for a DMA engine to consume. Each request carries a source address, a destination address, a byte length and two flags: fence and interrupt. A copy longer than the selected maximum chunk size is cut into several copy descriptors. The addresses advance by the length of each chunk, and the last chunk carries the remainder. After the chunks come the status descriptors: one for a fence, and two for an interrupt request. These descriptors write a zero word to a fixed scratch address, and only the last one raises an interrupt.

The block keeps the software head index and checks the free space of the ring against the engine's tail index. Before it writes anything, it refuses any request that does not fit, or that is misaligned or empty. It records the head at the end of each successful request as the submitted index. It publishes a new head to the engine only when enough entries are waiting or when an explicit issue is requested. It never publishes the same head value twice in a row.

Handshakes: the request side is valid/ready. `req_ready` is high only while the block is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The descriptor write port is valid/ready. Once `dw_valid` rises, `dw_idx` and `dw_data` stay stable until a clock edge with `dw_ready` high. Exactly one descriptor is written on each such edge. The outcome of each request is a one-cycle `rsp_valid` pulse, with `rsp_err` qualifying it.

Top module: `dma_desc_splitter`

## Requirements
- R1: A copy descriptor holds the source address in bits [45:0] and the length in 64-byte units in bits [63:46] (word 0 = dw_data[63:0]). Word 1 (dw_data[127:64]) holds the destination address in bits [59:0] and type code 1 in bits [63:60].
- R2: A copy is cut into chunks of at most 1,048,512 bytes when `big_chunk`=1, or at most 524,288 bytes when `big_chunk`=0. Source and destination advance by each chunk's length, and the last chunk carries the remainder.
- R3: A fence appends one status descriptor after the chunks. Its word 0 is zero. Its word 1 holds type code 2 in bits [63:60], bit 59 clear, and `stat_addr` in its low bits.
- R4: An interrupt appends two status descriptors in the R3 format, after the fence descriptor if there is one. Bit 59 of word 1 is set on the second descriptor only.
- R5: Free slots = (tail − head − 1) mod ring size. A request needs (number of chunks) + 3 slots. When free slots are fewer than that, the request is answered with `rsp_err`=1 and no descriptor is written.
- R6: A request is answered with `rsp_err`=1 and no descriptor is written in either of these cases: any of the low 6 bits of the source, destination or length is non-zero, or the length is zero with neither flag set.
- R7: Descriptors go to consecutive ring indices starting at head, wrapping modulo the ring size. `dw_valid` holds its data and index until `dw_ready` is high.
- R8: When a request completes and the count of submitted-but-unissued entries exceeds 4, the block emits one `head_wr_valid` pulse carrying the submitted index.
- R9: A one-cycle `issue_req` publishes the submitted index when it differs from the last issued one. Otherwise `issue_req` has no effect and no head write happens.
- R10: After reset, head, submitted and issued are 0, `req_ready` is 1, and `dw_valid`, `rsp_valid` and `head_wr_valid` are 0.
- R11: Each accepted request yields exactly one `rsp_valid` pulse. No descriptor is written while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_chunk | input | 1 | 1: max chunk 1 MiB − 64; 0: max chunk 512 KiB |
| stat_addr | input | ADDR_W | Scratch address written by status descriptors |
| tail_idx | input | RING_AW | Engine completion index |
| issue_req | input | 1 | Explicit request to publish the head |
| req_valid | input | 1 | Copy request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_src | input | ADDR_W | Source address |
| req_dst | input | ADDR_W | Destination address |
| req_len | input | LEN_W | Byte length |
| req_fence | input | 1 | Append fence status descriptor |
| req_intr | input | 1 | Append interrupt status pair |
| rsp_valid | output | 1 | Request outcome pulse |
| rsp_err | output | 1 | Request refused |
| dw_valid | output | 1 | Descriptor write valid |
| dw_ready | input | 1 | Descriptor write accepted |
| dw_idx | output | RING_AW | Ring slot being written |
| dw_data | output | 128 | Descriptor, word 1 in [127:64] |
| head_wr_valid | output | 1 | Head publication pulse |
| head_wr_value | output | RING_AW | Published head |

## Verification
The bench runs a copy that ends in a 128-byte remainder under each chunk size. A splitter with a wrong chunk limit or address stepping would emit the wrong number of chunks or the wrong addresses. It fills the ring so that free space is exactly the need, one short of it, and zero. A design with an off-by-one in the space formula would either write past the tail or refuse a request that fits. It sends an explicit issue with nothing pending, which a careless design would answer with a repeated head write that the engine treats as an overrun. It also sends a combined fence-and-interrupt request, where a wrong interrupt bit or a wrong ordering of the status descriptors shows up directly in the scoreboard.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int DDS_ALIGN_SH = 6;
  localparam int DDS_LEN_LSB  = 46;
  localparam int DDS_TYPE_LSB = 60;
  localparam int DDS_IRQ_BIT  = 59;
  localparam int DDS_RESV     = 3;
  localparam logic [3:0] DDS_T_COPY = 4'd1;
  localparam logic [3:0] DDS_T_STAT = 4'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_SIZE, S_COPY, S_FENCE, S_INT0, S_INT1, S_DONE
  } dds_state_e;

  function automatic logic [127:0] dds_copy_desc(logic [63:0] src, logic [63:0] dst,
                                                 logic [63:0] nbytes);
    logic [63:0] w0;
    logic [63:0] w1;
    w0 = src | ((nbytes >> DDS_ALIGN_SH) << DDS_LEN_LSB);
    w1 = dst | (64'(DDS_T_COPY) << DDS_TYPE_LSB);
    return {w1, w0};
  endfunction

  function automatic logic [127:0] dds_stat_desc(logic [63:0] addr, logic irq);
    logic [63:0] w1;
    w1 = addr | (64'(DDS_T_STAT) << DDS_TYPE_LSB) | (64'(irq) << DDS_IRQ_BIT);
    return {w1, 64'd0};
  endfunction
endpackage

// File: rtl/dds_ring_space.sv
module dds_ring_space #(
  parameter int RING_AW = 7
) (
  input  logic [RING_AW-1:0] head,
  input  logic [RING_AW-1:0] tail,
  output logic [RING_AW:0]   free_slots
);
  localparam logic [RING_AW:0] RING_N = (RING_AW+1)'(1) << RING_AW;

  logic [RING_AW:0] head_x;
  logic [RING_AW:0] tail_x;

  assign head_x = {1'b0, head};
  assign tail_x = {1'b0, tail};

  // one slot always stays empty so that full and empty differ
  always_comb begin
    if (head_x >= tail_x) free_slots = tail_x + RING_N - head_x - 1'b1;
    else                  free_slots = tail_x - head_x - 1'b1;
  end
endmodule

// File: rtl/dds_chunk_sizer.sv
module dds_chunk_sizer #(
  parameter int LEN_W  = 32,
  parameter int FREE_W = 8,
  parameter int RESV   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [FREE_W-1:0] free_slots,
  output logic              done,
  output logic              fits
);
  localparam int CNT_W = FREE_W + 1;
  localparam logic [CNT_W-1:0] RESV_V = CNT_W'(RESV);

  logic [LEN_W-1:0]  rem_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FREE_W-1:0] free_q;
  logic              busy_q;
  logic [LEN_W-1:0]  step;
  logic [CNT_W-1:0]  free_x;

  assign step   = (rem_q < max_len) ? rem_q : max_len;
  assign free_x = {1'b0, free_q};

  // counts chunks one per cycle and stops early once the need exceeds the space
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      free_q <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
      fits   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= len;
        cnt_q  <= '0;
        free_q <= free_slots;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (rem_q == '0) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          fits   <= (cnt_q + RESV_V) <= free_x;
        end else if ((cnt_q + RESV_V + 1'b1) > free_x) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          fits   <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          rem_q <= rem_q - step;
        end
      end
    end
  end
endmodule

// File: rtl/dds_head_pub.sv
module dds_head_pub #(
  parameter int RING_AW = 7,
  parameter int HWM     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               submit,
  input  logic [RING_AW-1:0] submit_idx,
  input  logic               issue_req,
  output logic               pub_valid,
  output logic [RING_AW-1:0] pub_value
);
  localparam logic [RING_AW-1:0] HWM_V = RING_AW'(HWM);

  logic [RING_AW-1:0] sub_q;
  logic [RING_AW-1:0] iss_q;
  logic [RING_AW-1:0] pend;
  logic               go;

  assign pend = sub_q - iss_q;
  assign go   = (pend > HWM_V) || (issue_req && (pend != '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q     <= '0;
      iss_q     <= '0;
      pub_valid <= 1'b0;
      pub_value <= '0;
    end else begin
      if (submit) sub_q <= submit_idx;
      pub_valid <= go;
      if (go) begin
        iss_q     <= sub_q;
        pub_value <= sub_q;
      end
    end
  end
endmodule

// File: rtl/dma_desc_splitter.sv
module dma_desc_splitter #(
  parameter int ADDR_W  = 40,
  parameter int LEN_W   = 32,
  parameter int RING_AW = 7,
  parameter int HWM     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               big_chunk,
  input  logic [ADDR_W-1:0]  stat_addr,
  input  logic [RING_AW-1:0] tail_idx,
  input  logic               issue_req,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_src,
  input  logic [ADDR_W-1:0]  req_dst,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               req_fence,
  input  logic               req_intr,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic               dw_valid,
  input  logic               dw_ready,
  output logic [RING_AW-1:0] dw_idx,
  output logic [127:0]       dw_data,
  output logic               head_wr_valid,
  output logic [RING_AW-1:0] head_wr_value
);
  import dds_pkg::*;

  localparam int FREE_W = RING_AW + 1;
  localparam logic [LEN_W-1:0] MAX_BIG   = LEN_W'((1 << 20) - (1 << DDS_ALIGN_SH));
  localparam logic [LEN_W-1:0] MAX_SMALL = LEN_W'(1 << 19);

  dds_state_e         state_q;
  logic [ADDR_W-1:0]  src_q;
  logic [ADDR_W-1:0]  dst_q;
  logic [LEN_W-1:0]   rem_q;
  logic [LEN_W-1:0]   max_q;
  logic               fence_q;
  logic               intr_q;
  logic               err_q;
  logic [RING_AW-1:0] head_q;
  logic [FREE_W-1:0]  free_slots;
  logic               sz_start;
  logic               sz_done;
  logic               sz_fits;
  logic               bad_req;
  logic [LEN_W-1:0]   cur_len;
  logic               wr_fire;

  function automatic dds_state_e after_copy(logic f, logic i);
    if (f)      return S_FENCE;
    else if (i) return S_INT0;
    else        return S_DONE;
  endfunction

  assign bad_req = (|req_src[DDS_ALIGN_SH-1:0]) | (|req_dst[DDS_ALIGN_SH-1:0])
                 | (|req_len[DDS_ALIGN_SH-1:0])
                 | ((req_len == '0) && !req_fence && !req_intr);
  assign req_ready = (state_q == S_IDLE);
  assign sz_start  = req_valid && req_ready && !bad_req;
  assign cur_len   = (rem_q < max_q) ? rem_q : max_q;
  assign wr_fire   = dw_valid && dw_ready;
  assign dw_idx    = head_q;
  assign rsp_valid = (state_q == S_DONE);
  assign rsp_err   = err_q;

  dds_ring_space #(.RING_AW(RING_AW)) u_space (
    .head       (head_q),
    .tail       (tail_idx),
    .free_slots (free_slots)
  );

  dds_chunk_sizer #(.LEN_W(LEN_W), .FREE_W(FREE_W), .RESV(DDS_RESV)) u_sizer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (sz_start),
    .len        (req_len),
    .max_len    (big_chunk ? MAX_BIG : MAX_SMALL),
    .free_slots (free_slots),
    .done       (sz_done),
    .fits       (sz_fits)
  );

  dds_head_pub #(.RING_AW(RING_AW), .HWM(HWM)) u_pub (
    .clk        (clk),
    .rst_n      (rst_n),
    .submit     (state_q == S_DONE && !err_q),
    .submit_idx (head_q),
    .issue_req  (issue_req),
    .pub_valid  (head_wr_valid),
    .pub_value  (head_wr_value)
  );

  always_comb begin
    dw_valid = 1'b0;
    dw_data  = '0;
    unique case (state_q)
      S_COPY: begin
        dw_valid = 1'b1;
        dw_data  = dds_copy_desc(64'(src_q), 64'(dst_q), 64'(cur_len));
      end
      S_FENCE, S_INT0: begin
        dw_valid = 1'b1;
        dw_data  = dds_stat_desc(64'(stat_addr), 1'b0);
      end
      S_INT1: begin
        dw_valid = 1'b1;
        dw_data  = dds_stat_desc(64'(stat_addr), 1'b1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      max_q   <= '0;
      fence_q <= 1'b0;
      intr_q  <= 1'b0;
      err_q   <= 1'b0;
      head_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid) begin
          src_q   <= req_src;
          dst_q   <= req_dst;
          rem_q   <= req_len;
          max_q   <= big_chunk ? MAX_BIG : MAX_SMALL;
          fence_q <= req_fence;
          intr_q  <= req_intr;
          err_q   <= bad_req;
          state_q <= bad_req ? S_DONE : S_SIZE;
        end
        S_SIZE: if (sz_done) begin
          if (!sz_fits) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end else if (rem_q != '0) begin
            state_q <= S_COPY;
          end else begin
            state_q <= after_copy(fence_q, intr_q);
          end
        end
        S_COPY: if (wr_fire) begin
          head_q <= head_q + 1'b1;
          src_q  <= src_q + ADDR_W'(cur_len);
          dst_q  <= dst_q + ADDR_W'(cur_len);
          rem_q  <= rem_q - cur_len;
          if (rem_q == cur_len) state_q <= after_copy(fence_q, intr_q);
        end
        S_FENCE: if (wr_fire) begin
          head_q  <= head_q + 1'b1;
          state_q <= intr_q ? S_INT0 : S_DONE;
        end
        S_INT0: if (wr_fire) begin
          head_q  <= head_q + 1'b1;
          state_q <= S_INT1;
        end
        S_INT1: if (wr_fire) begin
          head_q  <= head_q + 1'b1;
          state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dds_checker.sv
module dds_checker #(
  parameter int RING_AW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               dw_valid,
  input logic               dw_ready,
  input logic [RING_AW-1:0] dw_idx,
  input logic [127:0]       dw_data,
  input logic [RING_AW-1:0] tail_idx,
  input logic               head_wr_valid,
  input logic [RING_AW-1:0] head_wr_value
);
  logic [RING_AW-1:0] exp_idx;
  logic [RING_AW-1:0] last_pub;
  logic               have_pub;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_idx  <= '0;
      last_pub <= '0;
      have_pub <= 1'b0;
    end else begin
      if (dw_valid && dw_ready) exp_idx <= exp_idx + 1'b1;
      if (head_wr_valid) begin
        last_pub <= head_wr_value;
        have_pub <= 1'b1;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && !dw_ready |=> dw_valid && $stable(dw_data) && $stable(dw_idx));

  p_seq_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> dw_idx == exp_idx);

  p_no_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> RING_AW'(dw_idx + 1'b1) != tail_idx);

  p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr_valid && have_pub |-> head_wr_value != last_pub);

  p_pub_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    head_wr_valid |=> !head_wr_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !dw_valid);
endmodule

bind dma_desc_splitter dds_checker #(.RING_AW(RING_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .dw_valid      (dw_valid),
  .dw_ready      (dw_ready),
  .dw_idx        (dw_idx),
  .dw_data       (dw_data),
  .tail_idx      (tail_idx),
  .head_wr_valid (head_wr_valid),
  .head_wr_value (head_wr_value)
);

// File: tb/test_dma_desc_splitter.sv
`timescale 1ns/1ps
module test_dma_desc_splitter;
  localparam int RING = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         big_chunk = 1'b0;
  logic [39:0]  stat_addr = 40'h00_0ABC_0040;
  logic [6:0]   tail_idx = '0;
  logic         issue_req = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [39:0]  req_src = '0;
  logic [39:0]  req_dst = '0;
  logic [31:0]  req_len = '0;
  logic         req_fence = 1'b0;
  logic         req_intr = 1'b0;
  logic         rsp_valid;
  logic         rsp_err;
  logic         dw_valid;
  logic         dw_ready = 1'b0;
  logic [6:0]   dw_idx;
  logic [127:0] dw_data;
  logic         head_wr_valid;
  logic [6:0]   head_wr_value;

  int n_checks = 0;
  int n_fails  = 0;
  int hb = 0;
  int sub = 0;
  int iss = 0;
  int cyc = 0;

  logic [127:0] exp_d[$];
  logic [6:0]   exp_i[$];
  string        exp_t[$];
  logic [6:0]   exp_pub[$];

  dma_desc_splitter i_dma_desc_splitter (
    .clk(clk), .rst_n(rst_n), .big_chunk(big_chunk), .stat_addr(stat_addr),
    .tail_idx(tail_idx), .issue_req(issue_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
    .req_fence(req_fence), .req_intr(req_intr), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .dw_valid(dw_valid), .dw_ready(dw_ready), .dw_idx(dw_idx),
    .dw_data(dw_data), .head_wr_valid(head_wr_valid), .head_wr_value(head_wr_value)
  );

  always #5 clk = ~clk;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // back-pressure on the write port: three cycles ready, one stalled
  initial forever begin
    @(posedge clk);
    #2;
    cyc++;
    dw_ready = (cyc % 4) != 3;
  end

  // monitor: descriptor writes
  always @(negedge clk) begin
    if (rst_n && dw_valid && dw_ready) begin
      if (exp_d.size() == 0) begin
        check(1'b0, "R5/R6 unexpected descriptor", dw_data, '0);
      end else begin
        logic [127:0] d;
        logic [6:0]   ix;
        string        t;
        d = exp_d.pop_front();
        ix = exp_i.pop_front();
        t = exp_t.pop_front();
        check(dw_data == d, t, dw_data, d);
        check(dw_idx == ix, "R7 ring index", 128'(dw_idx), 128'(ix));
      end
    end
  end

  // monitor: head publications
  always @(negedge clk) begin
    if (rst_n && head_wr_valid) begin
      if (exp_pub.size() == 0) begin
        check(1'b0, "R9 unexpected head write", 128'(head_wr_value), '0);
      end else begin
        logic [6:0] p;
        p = exp_pub.pop_front();
        check(head_wr_value == p, "R8 published head", 128'(head_wr_value), 128'(p));
      end
    end
  end

  function automatic logic [127:0] exp_copy(longint src, longint dst, longint nb);
    logic [63:0] w0;
    logic [63:0] w1;
    w0 = {18'(nb >> 6), 46'(src)};
    w1 = {4'h1, 60'(dst)};
    return {w1, w0};
  endfunction

  function automatic logic [127:0] exp_stat(bit irq);
    return {4'h2, irq, 59'(stat_addr), 64'd0};
  endfunction

  task automatic push_desc(logic [127:0] d, string t);
    exp_d.push_back(d);
    exp_i.push_back(7'(hb));
    exp_t.push_back(t);
    hb = (hb + 1) % RING;
  endtask

  task automatic send(longint src, longint dst, longint len, bit f, bit irq, bit sel,
                      string tag);
    longint maxl;
    longint chunks;
    int     need;
    int     freec;
    bit     bad;
    bit     ok;
    maxl  = sel ? 64'd1048512 : 64'd524288;
    chunks = (len + maxl - 1) / maxl;
    need  = int'(chunks) + 3;
    freec = (int'(tail_idx) + RING - hb - 1) % RING;
    bad   = (src % 64 != 0) || (dst % 64 != 0) || (len % 64 != 0) || (len == 0 && !f && !irq);
    ok    = !bad && (need <= freec);
    if (ok) begin
      longint rem;
      longint s;
      longint d;
      rem = len; s = src; d = dst;
      while (rem > 0) begin
        longint c;
        c = (rem < maxl) ? rem : maxl;
        push_desc(exp_copy(s, d, c), {"R1/R2 copy chunk ", tag});
        s += c; d += c; rem -= c;
      end
      if (f) push_desc(exp_stat(1'b0), {"R3 fence status ", tag});
      if (irq) begin
        push_desc(exp_stat(1'b0), {"R4 first intr status ", tag});
        push_desc(exp_stat(1'b1), {"R4 second intr status ", tag});
      end
      sub = hb;
      if (((sub - iss + RING) % RING) > 4) begin
        exp_pub.push_back(7'(sub));
        iss = sub;
      end
    end
    @(negedge clk);
    big_chunk = sel;
    req_src = 40'(src); req_dst = 40'(dst); req_len = 32'(len);
    req_fence = f; req_intr = irq; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_err == !ok, {"R5/R6/R11 response ", tag}, 128'(rsp_err), 128'(!ok));
    @(negedge clk);
    check(!rsp_valid, {"R11 single response ", tag}, 128'(rsp_valid), 128'd0);
    repeat (4) @(negedge clk);
    check(exp_d.size() == 0, {"R7 all descriptors written ", tag}, 128'(exp_d.size()), 128'd0);
  endtask

  task automatic issue;
    if (sub != iss) begin
      exp_pub.push_back(7'(sub));
      iss = sub;
    end
    @(negedge clk);
    issue_req = 1'b1;
    @(negedge clk);
    issue_req = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_pub.size() == 0, "R9 issue outcome", 128'(exp_pub.size()), 128'd0);
  endtask

  initial begin
    #2_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(req_ready == 1'b1, "R10 ready after reset", 128'(req_ready), 128'd1);
    check(dw_valid == 1'b0, "R10 no write after reset", 128'(dw_valid), 128'd0);
    check(rsp_valid == 1'b0, "R10 no response after reset", 128'(rsp_valid), 128'd0);
    check(head_wr_valid == 1'b0, "R10 no head write after reset", 128'(head_wr_valid), 128'd0);

    send(64'h1000, 64'h2000, 256, 0, 0, 0, "single");
    send(64'h3000, 64'h4000, 128, 1, 0, 0, "fence");
    send(64'h5000, 64'h6000, 64, 0, 1, 0, "intr hwm");          // R8: pending 6
    issue();                                                     // R9: nothing pending
    send(64'h10_0000, 64'h80_0000, 1572992, 0, 0, 0, "small max"); // R2 remainder 128
    issue();                                                     // R9: publishes
    send(64'h100_0000, 64'h200_0000, 2097152, 1, 1, 1, "big max");  // R2/R4
    send(64'h1010, 64'h2000, 256, 0, 0, 0, "misaligned");       // R6
    send(64'h1000, 64'h2000, 0, 0, 0, 0, "empty");              // R6
    send(64'h0, 64'h0, 0, 1, 1, 0, "status only");              // R3/R4
    issue();

    // ring fill and wrap
    @(negedge clk);
    tail_idx = 7'(hb);
    send(64'h0, 64'h400_0000, 120 * 524288, 0, 0, 0, "bulk wrap");   // R7 wrap
    send(64'h0, 64'h0, 5 * 524288, 0, 0, 0, "one short");           // R5 reject
    send(64'h0, 64'h0, 4 * 524288, 0, 0, 0, "exact fit");           // R5 accept
    send(64'h0, 64'h0, 0, 1, 1, 0, "last slots");
    send(64'h0, 64'h0, 0, 1, 0, 0, "ring full");                    // R5 reject
    @(negedge clk);
    tail_idx = 7'(hb);
    send(64'h40, 64'h80, 64, 1, 0, 0, "after drain");
    issue();

    repeat (10) @(negedge clk);
    check(exp_d.size() == 0 && exp_pub.size() == 0, "R7/R8 scoreboard drained",
          128'(exp_d.size() + exp_pub.size()), 128'd0);
    report();
    $finish;
  end
endmodule